// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block holds a 2 KB bank of shared counters. Requesters update these counters atomically, one command per cycle. Everything that selects the counter sits in the request address. That includes the byte selector, the operand width and, for the fetching commands, a signed 22-bit increment. A fetch returns the operand's value from before the update and writes back that value plus the increment. A store command takes its operand from the write-data bus and either adds it to the counter or overwrites it.

A posted fetch behaves like a fetch, but its result is not returned on the load path. Instead the result leaves on a separate output together with the number of the 8-byte scratch slot that should receive it. When a fetch sets its wait flag, the block returns a result word whose top bit marks the data as invalid. The `tag_pending` input drives that bit; it stands in for a tag switch that has not yet completed.

Operands of 1, 2, 4 and 8 bytes sit little-endian inside 64-bit words. Each operand must be naturally aligned. Sums wrap modulo the operand width, and no other byte of the word changes. A malformed request produces a one-cycle error pulse and leaves the bank untouched.

Top module: `fadd_unit`

## Requirements
- R1: A synchronous active-low reset clears every counter to zero and holds `rsp_valid`, `post_valid` and `err_valid` low.
- R2: A fetch (`req_kind`=0) returns the prior operand, sign-extended to 64 bits, on `rsp_data`, with `rsp_valid` high in the cycle after the request. It stores the prior value plus the increment in address bits 35:14, sign-extended. Without a request, no valid output rises.
- R3: Address bits 12:11 select the operand width: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. All sums wrap modulo that width.
- R4: Address bits 10:0 form a byte address. Bits 10:3 pick the 64-bit word and bits 2:0 give the byte offset of a little-endian operand. Only the operand's bytes change.
- R5: A store (`req_kind`=1) uses the width in bits 12:11 and the low bits of `req_wdata`. With address bit 13 clear it adds them to the operand; with bit 13 set it overwrites the operand. A store raises no valid output.
- R6: A fetch with address bit 13 set returns a result whose bit 63 equals `tag_pending`. When that bit is 0, bits 62:0 carry the prior value. The update is applied in either case.
- R7: A posted fetch (`req_kind`=2) updates the counter like a fetch. It raises `post_valid` instead of `rsp_valid`, with `post_slot` taken from address bits 63:56 and the result on `post_data`. Its length field in bits 55:48 must equal 1.
- R8: A misaligned operand, a posted fetch whose length field is not 1, and `req_kind`=3 each raise only `err_valid` in the next cycle. None of them changes the bank.
- R9: A request in the cycle right after an update observes that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command present this cycle |
| req_kind | input | 2 | 0 fetch, 1 store, 2 posted fetch, 3 reserved |
| req_addr | input | 64 | Command address with selector, width, flag, increment, length and slot |
| req_wdata | input | 64 | Store operand |
| tag_pending | input | 1 | Marks a waiting fetch result invalid |
| rsp_valid | output | 1 | Fetch result valid |
| rsp_data | output | 64 | Fetch result |
| post_valid | output | 1 | Posted result valid |
| post_slot | output | 8 | Destination scratch slot, in 8-byte units |
| post_data | output | 64 | Posted result |
| err_valid | output | 1 | Request rejected |

## Verification
The bench issues commands back to back, so a bank whose read path lagged one cycle would hand back stale prior values. Narrow operands are tested at non-zero offsets and made to wrap. A design with a wrong lane shift, a missing sign extension or a carry leaking into a neighbouring byte would show the damage on a later full-word fetch. A misaligned access and a posted fetch with a bad length are both followed by a read of the same counter, which exposes any design that updates before it rejects. The waiting fetch is run with the tag input both clear and set, and is followed by a plain fetch that proves the update still landed.

// File: rtl/fadd_pkg.sv
// Package: fadd_pkg
// Shared command encodings and address field positions for the fetch-and-add
// counter bank. Assumes a 64-bit command address with a fixed field layout.
package fadd_pkg;

    typedef enum logic [1:0] {
        CMD_FETCH = 2'd0,
        CMD_STORE = 2'd1,
        CMD_POST  = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } opsize_e;

    // Field positions inside the command address.
    localparam int FLD_SIZE_LSB = 11;
    localparam int FLD_FLAG_BIT = 13;
    localparam int FLD_INC_LSB  = 14;
    localparam int FLD_LEN_LSB  = 48;
    localparam int FLD_SLOT_LSB = 56;

endpackage

// File: rtl/fadd_decode.sv
// Module: fadd_decode
// Splits a command address into counter index, byte offset, width code,
// flag bit, sign-extended increment and scratch slot, and flags requests
// that must be rejected. Assumes the field layout in fadd_pkg.
module fadd_decode
    import fadd_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int SEL_W  = 11,
    parameter int INC_W  = 22,
    parameter int LEN_W  = 8,
    parameter int SLOT_W = 8,
    localparam int OFF_W = $clog2(DATA_W / 8),
    localparam int IDX_W = SEL_W - OFF_W
) (
    input  logic [1:0]        kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [OFF_W-1:0]  off_o,
    output logic [1:0]        size_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] inc_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              bad_o
);

    localparam int GAP_LSB = FLD_INC_LSB + INC_W;
    localparam int GAP_W   = FLD_LEN_LSB - GAP_LSB;

    logic [LEN_W-1:0] len;
    logic             misaligned;
    logic [GAP_W-1:0] unused_gap;
    cmd_e             kind;

    assign kind       = cmd_e'(kind_i);
    assign off_o      = addr_i[OFF_W-1:0];
    assign idx_o      = addr_i[SEL_W-1:OFF_W];
    assign size_o     = addr_i[FLD_SIZE_LSB +: 2];
    assign flag_o     = addr_i[FLD_FLAG_BIT];
    assign inc_o      = DATA_W'($signed(addr_i[FLD_INC_LSB +: INC_W]));
    assign len        = addr_i[FLD_LEN_LSB +: LEN_W];
    assign slot_o     = addr_i[FLD_SLOT_LSB +: SLOT_W];
    assign unused_gap = addr_i[GAP_LSB +: GAP_W];

    // Natural alignment check: low offset bits must be zero for the width.
    always_comb begin
        case (opsize_e'(size_o))
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off_o[0];
            SZ_WORD: misaligned = |off_o[1:0];
            default: misaligned = |off_o;
        endcase
    end

    // Rejection: reserved kind, misalignment, or a posted length other than one.
    assign bad_o = (kind == CMD_RSVD) || misaligned ||
                   ((kind == CMD_POST) && (len != LEN_W'(1)));

endmodule

// File: rtl/fadd_lane.sv
// Module: fadd_lane
// Combinational operand datapath. It extracts the addressed little-endian
// operand of each width, sign-extends the prior value, forms the wrapped sum
// or the overwrite value, and merges it back into the word. Assumes the
// offset is aligned, which the decoder checks.
module fadd_lane #(
    parameter int DATA_W = 64,
    localparam int OFF_W = $clog2(DATA_W / 8),
    localparam int NSIZE = OFF_W + 1
) (
    input  logic [DATA_W-1:0] old_word_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              overwrite_i,
    output logic [DATA_W-1:0] old_ext_o,
    output logic [DATA_W-1:0] new_word_o
);

    logic [OFF_W+2:0]  shift;
    logic [DATA_W-1:0] ext_c    [NSIZE];
    logic [DATA_W-1:0] merged_c [NSIZE];

    assign shift = {off_i, 3'b000};

    // One datapath per operand width; the width code picks among them below.
    for (genvar s = 0; s < NSIZE; s++) begin : g_size
        localparam int W = 8 << s;
        localparam logic [DATA_W-1:0] LMASK = {DATA_W{1'b1}} >> (DATA_W - W);
        logic [W-1:0] lane_old;
        logic [W-1:0] lane_new;

        assign lane_old    = W'(old_word_i >> shift);
        assign lane_new    = overwrite_i ? operand_i[W-1:0] : lane_old + operand_i[W-1:0];
        assign ext_c[s]    = DATA_W'($signed(lane_old));
        assign merged_c[s] = (old_word_i & ~(LMASK << shift)) | (DATA_W'(lane_new) << shift);
    end

    assign old_ext_o  = ext_c[size_i];
    assign new_word_o = merged_c[size_i];

endmodule

// File: rtl/fadd_regfile.sv
// Module: fadd_regfile
// Counter storage: WORDS words of DATA_W bits with one combinational read port
// and one synchronous write port. A write becomes visible to a read in the
// next cycle. Synchronous active-low reset clears every word.
module fadd_regfile #(
    parameter int DATA_W = 64,
    parameter int WORDS  = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    logic [DATA_W-1:0] mem [WORDS];

    assign rd_data_o = mem[rd_idx_i];

    // Storage update: clear on reset, else write the merged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[wr_idx_i] <= wr_data_i;
        end
    end

    // R9: a written word is in place for the very next cycle's read.
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem[$past(wr_idx_i)] == $past(wr_data_i)));

endmodule

// File: rtl/fadd_unit.sv
// Module: fadd_unit
// Atomic fetch-and-add counter bank. It takes one command per cycle, applies
// it to the addressed operand and registers the result onto the load path,
// the posted path or the error pulse one cycle later. Assumes that requesters
// keep their own ordering and that the scratch memory accepts every posted
// result.
module fadd_unit
    import fadd_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int SEL_W  = 11,
    parameter int INC_W  = 22,
    parameter int LEN_W  = 8,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tag_pending,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              post_valid,
    output logic [SLOT_W-1:0] post_slot,
    output logic [DATA_W-1:0] post_data,
    output logic              err_valid
);

    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int WORDS = (1 << SEL_W) / (DATA_W / 8);
    localparam int IDX_W = SEL_W - OFF_W;

    cmd_e              kind;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  off;
    logic [1:0]        size;
    logic              flag;
    logic [DATA_W-1:0] inc_ext;
    logic [SLOT_W-1:0] slot;
    logic              bad;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] old_ext;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] result;
    logic              overwrite;
    logic              wr_en;
    logic [DATA_W-1:0] span_mask;
    logic [DATA_W-1:0] lane_mask;

    assign kind = cmd_e'(req_kind);

    fadd_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
        .INC_W(INC_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W)
    ) u_decode (
        .kind_i (req_kind),
        .addr_i (req_addr),
        .idx_o  (idx),
        .off_o  (off),
        .size_o (size),
        .flag_o (flag),
        .inc_o  (inc_ext),
        .slot_o (slot),
        .bad_o  (bad)
    );

    fadd_regfile #(.DATA_W(DATA_W), .WORDS(WORDS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (idx),
        .rd_data_o (rd_word),
        .we_i      (wr_en),
        .wr_idx_i  (idx),
        .wr_data_i (wr_word)
    );

    fadd_lane #(.DATA_W(DATA_W)) u_lane (
        .old_word_i  (rd_word),
        .off_i       (off),
        .size_i      (size),
        .operand_i   (operand),
        .overwrite_i (overwrite),
        .old_ext_o   (old_ext),
        .new_word_o  (wr_word)
    );

    // Operand source: stores use the data bus, fetches use the address increment.
    assign operand   = (kind == CMD_STORE) ? req_wdata : inc_ext;
    assign overwrite = (kind == CMD_STORE) && flag;
    assign wr_en     = req_valid && !bad;

    // Result word: a waiting fetch puts the invalid flag in the top bit.
    assign result = ((kind != CMD_STORE) && flag) ?
                    {tag_pending, old_ext[DATA_W-2:0]} : old_ext;

    // Output registers: one outcome per accepted or rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            post_valid <= 1'b0;
            post_slot  <= '0;
            post_data  <= '0;
            err_valid  <= 1'b0;
        end else begin
            rsp_valid  <= wr_en && (kind == CMD_FETCH);
            post_valid <= wr_en && (kind == CMD_POST);
            err_valid  <= req_valid && bad;
            if (wr_en) begin
                rsp_data  <= result;
                post_data <= result;
                post_slot <= slot;
            end
        end
    end

    // Checker mask: the bytes the width code and offset allow to change.
    always_comb begin
        case (opsize_e'(size))
            SZ_BYTE: span_mask = DATA_W'(64'hFF);
            SZ_HALF: span_mask = DATA_W'(64'hFFFF);
            SZ_WORD: span_mask = DATA_W'(64'hFFFF_FFFF);
            default: span_mask = '1;
        endcase
        lane_mask = span_mask << {off, 3'b000};
    end

    // R4: a write changes no byte outside the addressed operand.
    p_lane_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (((wr_word ^ rd_word) & ~lane_mask) == '0));

    // R8: at most one outcome per cycle.
    p_single_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, post_valid, err_valid}));

    // R8: a rejected command wrote nothing.
    p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> !$past(wr_en));

    // R2: a load-path answer follows only a fetch request.
    p_fetch_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid) && ($past(req_kind) == 2'd0)));

    // R7: the posted slot is the one carried by the request.
    p_post_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |-> (post_slot == $past(req_addr[FLD_SLOT_LSB +: SLOT_W])));

    // R6: a waiting fetch under a pending tag returns an invalid result.
    p_tag_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_addr[FLD_FLAG_BIT]) && $past(tag_pending))
        |-> rsp_data[DATA_W-1]);

endmodule

// File: tb/fadd_unit_test.sv
`timescale 1ns/1ps
module fadd_unit_test;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  size;
        logic [10:0] sel;
        logic        tw;
        logic [21:0] inc;
        logic [7:0]  slot;
        logic [7:0]  len;
        logic [63:0] wdata;
        logic        tagp;
        logic [2:0]  expc;   // 0 none, 1 rsp, 2 post, 3 err, 4 rsp top bit only
        logic [63:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 2'd3, 11'h000, 1'b0, 22'd5,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'h0, 4'd2},                    // R2
        '{2'd0, 2'd3, 11'h000, 1'b0, 22'h3FFFFE,  8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'd5, 4'd2},                    // R2
        '{2'd1, 2'd3, 11'h000, 1'b0, 22'd0,       8'h00, 8'h00, 64'd10, 1'b0, 3'd0, 64'h0, 4'd5},                   // R5
        '{2'd0, 2'd3, 11'h000, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'd13, 4'd5},                   // R5
        '{2'd1, 2'd3, 11'h008, 1'b1, 22'd0,       8'h00, 8'h00, 64'h8000_0000_0000_00FF, 1'b0, 3'd0, 64'h0, 4'd5},  // R5
        '{2'd0, 2'd0, 11'h008, 1'b0, 22'd1,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd3},  // R3
        '{2'd0, 2'd3, 11'h008, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'h8000_0000_0000_0000, 4'd4},  // R4
        '{2'd0, 2'd1, 11'h00E, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'hFFFF_FFFF_FFFF_8000, 4'd4},  // R4
        '{2'd0, 2'd2, 11'h00C, 1'b0, 22'd7,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'hFFFF_FFFF_8000_0000, 4'd4},  // R4
        '{2'd0, 2'd3, 11'h008, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'h8000_0007_0000_0000, 4'd9},  // R9
        '{2'd0, 2'd1, 11'h009, 1'b0, 22'd1,       8'h00, 8'h00, 64'h0, 1'b0, 3'd3, 64'h0, 4'd8},                    // R8
        '{2'd0, 2'd3, 11'h008, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'h8000_0007_0000_0000, 4'd8},  // R8
        '{2'd2, 2'd3, 11'h000, 1'b0, 22'd1,       8'h2A, 8'h01, 64'h0, 1'b0, 3'd2, 64'd13, 4'd7},                   // R7
        '{2'd2, 2'd3, 11'h000, 1'b0, 22'd1,       8'h2B, 8'h02, 64'h0, 1'b0, 3'd3, 64'h0, 4'd7},                    // R7
        '{2'd0, 2'd3, 11'h000, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'd14, 4'd7},                   // R7
        '{2'd0, 2'd3, 11'h000, 1'b1, 22'd1,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'd14, 4'd6},                   // R6
        '{2'd0, 2'd3, 11'h000, 1'b1, 22'd1,       8'h00, 8'h00, 64'h0, 1'b1, 3'd4, 64'h0, 4'd6},                    // R6
        '{2'd0, 2'd3, 11'h000, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'd16, 4'd6},                   // R6
        '{2'd3, 2'd3, 11'h000, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd3, 64'h0, 4'd8},                    // R8
        '{2'd1, 2'd1, 11'h010, 1'b0, 22'd0,       8'h00, 8'h00, 64'h1234_FFFF, 1'b0, 3'd0, 64'h0, 4'd5},            // R5
        '{2'd1, 2'd1, 11'h010, 1'b0, 22'd0,       8'h00, 8'h00, 64'd1, 1'b0, 3'd0, 64'h0, 4'd3},                    // R3
        '{2'd0, 2'd3, 11'h010, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'h0, 4'd3},                    // R3
        '{2'd0, 2'd3, 11'h7F8, 1'b0, 22'h3FFFFF,  8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'h0, 4'd2},                    // R2
        '{2'd0, 2'd3, 11'h7F8, 1'b0, 22'h1FFFFF,  8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd3},  // R3
        '{2'd0, 2'd3, 11'h7F8, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'h1F_FFFE, 4'd3},              // R3
        '{2'd1, 2'd0, 11'h7FB, 1'b1, 22'd0,       8'h00, 8'h00, 64'hAB, 1'b0, 3'd0, 64'h0, 4'd4},                   // R4
        '{2'd0, 2'd3, 11'h7F8, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'hAB1F_FFFE, 4'd4},            // R4
        '{2'd0, 2'd0, 11'h7FB, 1'b0, 22'h55,      8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'hFFFF_FFFF_FFFF_FFAB, 4'd3},  // R3
        '{2'd0, 2'd3, 11'h7F8, 1'b0, 22'd0,       8'h00, 8'h00, 64'h0, 1'b0, 3'd1, 64'h001F_FFFE, 4'd3}             // R3
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [63:0] req_addr;
    logic [63:0] req_wdata;
    logic        tag_pending;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        post_valid;
    logic [7:0]  post_slot;
    logic [63:0] post_data;
    logic        err_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fadd_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .tag_pending(tag_pending),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .post_valid(post_valid),
        .post_slot(post_slot), .post_data(post_data), .err_valid(err_valid)
    );

    task automatic drive(input vec_t v);
        req_valid   = 1'b1;
        req_kind    = v.kind;
        req_addr    = {v.slot, v.len, 12'h000, v.inc, v.tw, v.size, v.sel};
        req_wdata   = v.wdata;
        tag_pending = v.tagp;
    endtask

    task automatic idle();
        req_valid   = 1'b0;
        req_kind    = 2'd0;
        req_addr    = '0;
        req_wdata   = '0;
        tag_pending = 1'b0;
    endtask

    task automatic check(input vec_t v);
        logic ok;
        logic [63:0] act;
        act = rsp_data;
        case (v.expc)
            3'd0: ok = !rsp_valid && !post_valid && !err_valid;
            3'd1: ok = rsp_valid && !post_valid && !err_valid && (rsp_data == v.data);
            3'd2: begin
                ok  = post_valid && !rsp_valid && !err_valid &&
                      (post_slot == v.slot) && (post_data == v.data);
                act = post_data;
            end
            3'd3: ok = err_valid && !rsp_valid && !post_valid;
            default: ok = rsp_valid && !post_valid && !err_valid && rsp_data[63];
        endcase
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: valids rsp/post/err=%b%b%b data=%h slot=%h, expected class %0d data=%h slot=%h",
                     v.req, rsp_valid, post_valid, err_valid, act, post_slot,
                     v.expc, v.data, v.slot);
        end
    endtask

    function automatic vec_t fetch64(input logic [10:0] sel, input logic [63:0] exp, input logic [3:0] r);
        return '{2'd0, 2'd3, sel, 1'b0, 22'd0, 8'h00, 8'h00, 64'h0, 1'b0, 3'd1, exp, r};
    endfunction

    localparam vec_t QUIET = '{2'd0, 2'd0, 11'h0, 1'b0, 22'd0, 8'h0, 8'h0, 64'h0, 1'b0, 3'd0, 64'h0, 4'd1};

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        check(QUIET);                                // R1: outputs low in reset
        rst_n = 1'b1;
        @(negedge clk);
        check(QUIET);                                // R1: still quiet after release
        // Table walk: commands back to back, each result checked one cycle later.
        for (int i = 0; i < NV; i++) begin
            if (i > 0) check(TBL[i-1]);
            drive(TBL[i]);
            @(negedge clk);
        end
        check(TBL[NV-1]);
        idle();
        @(negedge clk);
        check('{2'd0, 2'd0, 11'h0, 1'b0, 22'd0, 8'h0, 8'h0, 64'h0, 1'b0, 3'd0, 64'h0, 4'd2}); // R2: no request, no output
        // Directed: reset mid-run clears the counters (R1).
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(QUIET);                                // R1
        rst_n = 1'b1;
        drive(fetch64(11'h7F8, 64'h0, 4'd1));
        @(negedge clk);
        check(fetch64(11'h7F8, 64'h0, 4'd1));        // R1: top word cleared
        drive(fetch64(11'h008, 64'h0, 4'd1));
        @(negedge clk);
        check(fetch64(11'h008, 64'h0, 4'd1));        // R1: word 1 cleared
        drive(fetch64(11'h000, 64'h0, 4'd1));
        @(negedge clk);
        check(fetch64(11'h000, 64'h0, 4'd1));        // R1: word 0 cleared
        idle();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish before 20000 cycles");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule